// File: doc/BRIEF.md
# Timer interrupt router with legacy replacement

This block takes expiry events from a group of timer channels and places them on a bank of interrupt request lines. Each channel carries a 16-bit configuration word. The word selects the destination line, chooses level or edge signalling, and gates the channel on or off. A global enable covers every channel. Level-type channels keep a status bit and hold their line high until software asks for a deassert. Edge-type channels emit a single-cycle pulse on their line.

The block also forwards two external legacy interrupt sources, a periodic interval-timer input and a real-time-clock input, onto their fixed lines. When the legacy-replacement control is set, channel 0 and channel 1 take over those two lines and the external sources are silenced. An output tells the external interval timer whether it may drive. The real-time-clock level is recorded at all times, so leaving legacy mode puts the current clock level back on its line. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `trt_router`

## Requirements
- R1: While reset is asserted and right after it, every irq line and every status bit is 0 and pit_oe is 1.
- R2: Outside legacy mode, a channel's contribution appears on the line whose index is held in configuration bits 13:9 (route field). It appears one clock after the expiry input is sampled.
- R3: While legacy mode is on (as registered one clock earlier), channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. Channels 2 and up keep using their route field.
- R4: A fire on an enabled channel whose configuration bit 1 is 1 (level type) sets its status bit and holds its line high on every following cycle until the channel is cleared.
- R5: A fire on an enabled channel whose configuration bit 1 is 0 (edge type) raises its line for exactly one cycle, one clock later, and leaves its status bit at 0.
- R6: A clear request, configuration bit 2 (channel enable) at 0, or glb_en at 0 drops the channel's status bit and its line on the next clock. Clear wins over a simultaneous fire, and a fire while disabled has no effect.
- R7: pit_oe is the inverse of legacy_mode, delayed by one clock. Entering legacy mode drives it low and leaving drives it high.
- R8: pit_in is copied to line 0, and rtc_in to line 8, one clock later, only while legacy mode is off. In legacy mode both inputs have no effect on any line, and entering the mode lowers lines 0 and 8.
- R9: The rtc_in level is recorded in every mode. On leaving legacy mode, line 8 shows the most recently recorded level.
- R10: When several channels resolve to the same line, that line is the OR of their contributions.
- R11: A route field value of NUM_IRQ or above drives no line, though the status bit still behaves per R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt generation enable |
| legacy_mode | input | 1 | Legacy-replacement control |
| ch_cfg | input | NUM_CH*16 | Per-channel configuration words, channel 0 in the low bits |
| ch_fire | input | NUM_CH | Per-channel expiry pulse |
| ch_clr | input | NUM_CH | Per-channel deassert request |
| pit_in | input | 1 | External interval-timer interrupt level |
| rtc_in | input | 1 | External real-time-clock interrupt level |
| irq | output | NUM_IRQ | Interrupt request lines |
| status | output | NUM_CH | Level-type interrupt status bits |
| pit_oe | output | 1 | Output enable for the external interval timer |

## Verification
The bench builds the router with four channels and the default 24 lines. This leaves two channels, 2 and 3, that never take a legacy override. Those two can share a line, use an out-of-range route, and show in legacy mode that only channels 0 and 1 are redirected. With four channels, the legacy override, line sharing and edge pulses can all be checked against one another in the same run.

// File: rtl/trt_pkg.sv
package trt_pkg;
  localparam int CFG_W     = 16;
  localparam int LVL_BIT   = 1;   // 1 = level type, 0 = edge type
  localparam int EN_BIT    = 2;   // channel enable
  localparam int ROUTE_LSB = 9;   // route field position
  localparam int ROUTE_W   = 5;
  typedef logic [CFG_W-1:0]   chan_cfg_t;
  typedef logic [ROUTE_W-1:0] route_t;

  function automatic route_t cfg_route(chan_cfg_t c);
    return c[ROUTE_LSB +: ROUTE_W];
  endfunction
endpackage

// File: rtl/trt_chan.sv
module trt_chan
  import trt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      glb_en,
  input  logic      fire,
  input  logic      clr,
  input  chan_cfg_t cfg,
  output logic      status,
  output logic      pulse
);
  logic live;
  assign live = glb_en & cfg[EN_BIT] & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (!live) begin
        status <= 1'b0;
      end else if (fire) begin
        if (cfg[LVL_BIT]) status <= 1'b1;
        else              pulse  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trt_route.sv
module trt_route
  import trt_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int NUM_IRQ    = 24,
  parameter int LEG_LO_IRQ = 0,
  parameter int LEG_HI_IRQ = 8
) (
  input  logic                    legacy_q,
  input  logic [NUM_CH-1:0]       contrib,
  input  logic [NUM_CH*CFG_W-1:0] cfg_flat,
  output logic [NUM_IRQ-1:0]      lines
);
  route_t sel [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    route_t field;
    assign field = cfg_route(cfg_flat[c*CFG_W +: CFG_W]);
    if (c == 0) begin : g_lo
      assign sel[c] = legacy_q ? route_t'(LEG_LO_IRQ) : field;
    end else if (c == 1) begin : g_hi
      assign sel[c] = legacy_q ? route_t'(LEG_HI_IRQ) : field;
    end else begin : g_plain
      assign sel[c] = field;
    end
  end

  always_comb begin
    lines = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (contrib[c] && (int'(sel[c]) < NUM_IRQ)) lines[sel[c]] = 1'b1;
    end
  end
endmodule

// File: rtl/trt_legacy.sv
module trt_legacy (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy_mode,
  input  logic pit_in,
  input  logic rtc_in,
  output logic legacy_q,
  output logic pit_oe,
  output logic pit_fwd,
  output logic rtc_fwd
);
  logic pit_lvl, rtc_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_q <= 1'b0;
      pit_lvl  <= 1'b0;
      rtc_lvl  <= 1'b0;
    end else begin
      legacy_q <= legacy_mode;
      pit_lvl  <= pit_in;
      rtc_lvl  <= rtc_in;
    end
  end

  assign pit_oe  = ~legacy_q;
  assign pit_fwd = ~legacy_q & pit_lvl;
  assign rtc_fwd = ~legacy_q & rtc_lvl;
endmodule

// File: rtl/trt_router.sv
module trt_router
  import trt_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int NUM_IRQ    = 24,
  parameter int LEG_LO_IRQ = 0,
  parameter int LEG_HI_IRQ = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic                    legacy_mode,
  input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input  logic [NUM_CH-1:0]       ch_fire,
  input  logic [NUM_CH-1:0]       ch_clr,
  input  logic                    pit_in,
  input  logic                    rtc_in,
  output logic [NUM_IRQ-1:0]      irq,
  output logic [NUM_CH-1:0]       status,
  output logic                    pit_oe
);
  logic [NUM_CH-1:0]  pulse;
  logic [NUM_IRQ-1:0] lines;
  logic legacy_q, pit_fwd, rtc_fwd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    trt_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .glb_en (glb_en),
      .fire   (ch_fire[c]),
      .clr    (ch_clr[c]),
      .cfg    (ch_cfg[c*CFG_W +: CFG_W]),
      .status (status[c]),
      .pulse  (pulse[c])
    );
  end

  trt_legacy u_leg (
    .clk         (clk),
    .rst_n       (rst_n),
    .legacy_mode (legacy_mode),
    .pit_in      (pit_in),
    .rtc_in      (rtc_in),
    .legacy_q    (legacy_q),
    .pit_oe      (pit_oe),
    .pit_fwd     (pit_fwd),
    .rtc_fwd     (rtc_fwd)
  );

  trt_route #(
    .NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ),
    .LEG_LO_IRQ(LEG_LO_IRQ), .LEG_HI_IRQ(LEG_HI_IRQ)
  ) u_route (
    .legacy_q (legacy_q),
    .contrib  (status | pulse),
    .cfg_flat (ch_cfg),
    .lines    (lines)
  );

  always_comb begin
    irq = lines;
    irq[LEG_LO_IRQ] = lines[LEG_LO_IRQ] | pit_fwd;
    irq[LEG_HI_IRQ] = lines[LEG_HI_IRQ] | rtc_fwd;
  end
endmodule

// File: rtl/trt_router_chk.sv
module trt_router_chk
  import trt_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int NUM_IRQ    = 24,
  parameter int LEG_LO_IRQ = 0,
  parameter int LEG_HI_IRQ = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    glb_en,
  input logic                    legacy_mode,
  input logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input logic [NUM_CH-1:0]       ch_fire,
  input logic [NUM_CH-1:0]       ch_clr,
  input logic [NUM_IRQ-1:0]      irq,
  input logic [NUM_CH-1:0]       status,
  input logic                    pit_oe
);
  assert_reset_state_R1: assert property (@(posedge clk)
    (!rst_n && !$past(rst_n)) |-> (status == '0 && irq == '0 && pit_oe));

  assert_pit_oe_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pit_oe == !$past(legacy_mode)));

  assert_global_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(glb_en)) |-> (status == '0));

  assert_legacy_silences_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !pit_oe && status == '0 && $past(ch_fire) == '0)
      |-> (!irq[LEG_LO_IRQ] && !irq[LEG_HI_IRQ]));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_edge_no_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(status[c]) && !$past(ch_cfg[c*CFG_W+LVL_BIT]))
        |-> !status[c]);

    assert_level_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(status[c]) && $past(glb_en) &&
       $past(ch_cfg[c*CFG_W+EN_BIT]) && !$past(ch_clr[c])) |-> status[c]);
  end
endmodule

bind trt_router trt_router_chk #(
  .NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ),
  .LEG_LO_IRQ(LEG_LO_IRQ), .LEG_HI_IRQ(LEG_HI_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_mode(legacy_mode),
  .ch_cfg(ch_cfg), .ch_fire(ch_fire), .ch_clr(ch_clr),
  .irq(irq), .status(status), .pit_oe(pit_oe)
);

// File: tb/sim_trt_router.sv
`timescale 1ns/1ps
module sim_trt_router;
  localparam int NCH  = 4;
  localparam int NIRQ = 24;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0, legacy_mode = 1'b0, pit_in = 1'b0, rtc_in = 1'b0;
  logic [NCH*CW-1:0] ch_cfg = '0;
  logic [NCH-1:0] ch_fire = '0, ch_clr = '0;
  logic [NIRQ-1:0] irq;
  logic [NCH-1:0] status;
  logic pit_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  trt_router #(.NUM_CH(NCH), .NUM_IRQ(NIRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_mode(legacy_mode),
    .ch_cfg(ch_cfg), .ch_fire(ch_fire), .ch_clr(ch_clr),
    .pit_in(pit_in), .rtc_in(rtc_in),
    .irq(irq), .status(status), .pit_oe(pit_oe)
  );

  function automatic logic [CW-1:0] mk_cfg(int route, bit level, bit en);
    logic [CW-1:0] w = '0;
    w[13:9] = route[4:0];
    w[1]    = level;
    w[2]    = en;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_cfg(int c, int route, bit level, bit en);
    ch_cfg[c*CW +: CW] = mk_cfg(route, level, en);
  endtask

  task automatic fire(logic [NCH-1:0] m);
    ch_fire = m; tick(); ch_fire = '0;
  endtask

  task automatic clear(logic [NCH-1:0] m);
    ch_clr = m; tick(); ch_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 irq at reset", 32'(irq), 0);
    chk("R1 status at reset", 32'(status), 0);
    chk("R1 pit_oe at reset", 32'(pit_oe), 1);
    rst_n = 1'b1; tick();
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 pit_oe after reset", 32'(pit_oe), 1);
  endtask

  task automatic t_level();
    glb_en = 1'b1;
    set_cfg(2, 5, 1, 1);
    fire(4'b0100);
    chk("R2 level routed to line 5", 32'(irq), 32'h20);
    chk("R4 status set", 32'(status), 32'h4);
    repeat (3) tick();
    chk("R4 line held", 32'(irq), 32'h20);
    clear(4'b0100);
    chk("R6 clear drops line", 32'(irq), 0);
    chk("R6 clear drops status", 32'(status), 0);
  endtask

  task automatic t_edge();
    set_cfg(3, 17, 0, 1);
    fire(4'b1000);
    chk("R5 edge pulse on line 17", 32'(irq), 32'h20000);
    chk("R5 edge leaves status clear", 32'(status), 0);
    tick();
    chk("R5 pulse lasts one cycle", 32'(irq), 0);
  endtask

  task automatic t_disable();
    set_cfg(2, 6, 1, 1);
    fire(4'b0100);
    chk("R4 status before disable", 32'(status), 32'h4);
    set_cfg(2, 6, 1, 0); tick();
    chk("R6 channel disable lowers line", 32'(irq), 0);
    fire(4'b0100);
    chk("R6 fire while disabled ignored", 32'(status), 0);
    set_cfg(2, 6, 1, 1);
    fire(4'b0100);
    glb_en = 1'b0; tick();
    chk("R6 global disable clears", 32'(status), 0);
    chk("R6 global disable lowers line", 32'(irq), 0);
    glb_en = 1'b1;
    ch_fire = 4'b0100; ch_clr = 4'b0100; tick();
    ch_fire = '0; ch_clr = '0;
    chk("R6 clear wins over fire", 32'(status), 0);
  endtask

  task automatic t_share();
    set_cfg(2, 11, 1, 1);
    set_cfg(3, 11, 1, 1);
    fire(4'b1100);
    chk("R10 shared line high", 32'(irq), 32'h800);
    clear(4'b0100);
    chk("R10 line kept by other channel", 32'(irq), 32'h800);
    clear(4'b1000);
    chk("R10 line low once both clear", 32'(irq), 0);
  endtask

  task automatic t_oob();
    set_cfg(2, 30, 1, 1);
    fire(4'b0100);
    chk("R11 out-of-range route drives nothing", 32'(irq), 0);
    chk("R11 status still set", 32'(status), 32'h4);
    clear(4'b0100);
  endtask

  task automatic t_legacy_route();
    set_cfg(0, 4, 1, 1);
    set_cfg(1, 4, 1, 1);
    set_cfg(2, 4, 1, 1);
    fire(4'b0001);
    chk("R3 ch0 uses route field outside legacy", 32'(irq), 32'h10);
    legacy_mode = 1'b1; tick();
    chk("R3 ch0 forced to line 0", 32'(irq), 32'h1);
    fire(4'b0010);
    chk("R3 ch1 forced to line 8", 32'(irq), 32'h101);
    fire(4'b0100);
    chk("R3 ch2 keeps route in legacy", 32'(irq), 32'h111);
    clear(4'b0111);
    chk("R3 all cleared", 32'(irq), 0);
    legacy_mode = 1'b0; tick();
  endtask

  task automatic t_legacy_io();
    pit_in = 1'b1; tick();
    chk("R8 pit forwarded to line 0", 32'(irq), 32'h1);
    rtc_in = 1'b1; tick();
    chk("R8 rtc forwarded to line 8", 32'(irq), 32'h101);
    legacy_mode = 1'b1; tick();
    chk("R7 entering legacy drops pit_oe", 32'(pit_oe), 0);
    chk("R8 entering legacy lowers 0 and 8", 32'(irq), 0);
    pit_in = 1'b0; tick(); pit_in = 1'b1; tick();
    chk("R8 pit ignored in legacy", 32'(irq), 0);
    rtc_in = 1'b0; tick();
    rtc_in = 1'b1; tick();
    chk("R8 rtc ignored in legacy", 32'(irq), 0);
    pit_in = 1'b0;
    legacy_mode = 1'b0; tick();
    chk("R7 leaving legacy raises pit_oe", 32'(pit_oe), 1);
    chk("R9 line 8 restored to rtc level", 32'(irq), 32'h100);
    rtc_in = 1'b0; tick();
    chk("R9 line 8 follows rtc again", 32'(irq), 0);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    t_level();
    t_edge();
    t_disable();
    t_share();
    t_oob();
    t_legacy_route();
    t_legacy_io();
    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule